// File: doc/BRIEF.md
# Serial Register Access Port

This block gives a debug host a bit-serial path to a bank of 32-bit registers. A TAP controller outside the block supplies three one-cycle strobes, capture, shift and update, and the block holds one 40-bit frame register between the host's serial input and output. The host shifts a whole frame through on every access. The frame carries a data word, a register address and a direction flag. On update, the block turns the frame into one access on a simple parallel bank interface.

Writes take effect at the update that ends their frame. Reads run one frame behind. The update of a read frame fetches the word, and the host sees that word only in the data field it shifts out during the next scan. A host that drains an auto-advancing location therefore repeats that address for every word except the last. For the last frame it reads a location with no side effect, so the window is not advanced one extra time.

Top module: `scan_reg_port`

## Requirements
- R1: A frame has 40 bits and is shifted least significant bit first. Bits 0 to 31 are the data word, bits 32 to 38 are the register address and bit 39 is the direction. On each shift strobe, `tdi` enters at bit 39 and `tdo` always shows bit 0.
- R2: When the frame at update has direction 1 (write), `bank_wr_en` is high for exactly one cycle, the cycle after the update strobe. In that cycle `bank_addr` and `bank_wr_data` carry the frame's address and data fields, and `bank_rd_en` stays low.
- R3: When the frame at update has direction 0 (read), `bank_rd_en` is high for exactly one cycle, the cycle after the update strobe, with `bank_addr` taken from the frame. `bank_wr_en` stays low.
- R4: The word on `bank_rd_data` during the read strobe is held. The next capture strobe loads it into bits 0 to 31, so it leaves on `tdo` during the first 32 shifts of the following scan.
- R5: A capture strobe clears bits 32 to 39 of the frame, so the last 8 bits shifted out of every scan are zero.
- R6: Each read frame produces exactly one read strobe. A burst of N reads of an auto-advancing location, closed by one read of a side-effect-free location, advances that location exactly N times.
- R7: Capture and shift strobes never start a bank access. A write frame leaves the held read word unchanged, so a capture after a write returns the word from the most recent read.
- R8: After reset, `tdo` is 0, both bank strobes are low, and the held read word is 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| capture_en | input | 1 | Capture strobe from the TAP controller |
| shift_en | input | 1 | Shift strobe, one bit per cycle |
| update_en | input | 1 | Update strobe; decodes the frame |
| tdi | input | 1 | Serial data in |
| tdo | output | 1 | Serial data out (frame bit 0) |
| bank_addr | output | 7 | Register address for the bank access |
| bank_wr_data | output | 32 | Write data for the bank |
| bank_wr_en | output | 1 | One-cycle write strobe |
| bank_rd_en | output | 1 | One-cycle read strobe |
| bank_rd_data | input | 32 | Read data from the bank, valid while `bank_rd_en` is high |

## Verification
The bench goes after the one-frame read lag. A design that returned read data in the same scan would shift out the previous word in the wrong frame, and every burst word would come back one position off. It drains a RAM window through an auto-advancing address and then reads back the window pointer. A design that strobed the read more than once per frame, or on capture, would show a pointer past the burst length. It also places a write between two reads and checks that the held word is unchanged. A design that refreshed the held word on every update would instead return whatever the bank drove during the write. Every scan also checks that the address and direction bits come out as zeros.

// File: rtl/scan_port_pkg.sv
package scan_port_pkg;
  localparam int SP_DATA_W = 32;
  localparam int SP_ADDR_W = 7;

  typedef enum logic {
    DIR_READ  = 1'b0,
    DIR_WRITE = 1'b1
  } scan_dir_e;
endpackage

// File: rtl/scan_frame_shifter.sv
module scan_frame_shifter #(
  parameter int DATA_W = 32,
  parameter int ADDR_W = 7
) (
  input  logic                         clk,
  input  logic                         rst_n,
  input  logic                         capture_en,
  input  logic                         shift_en,
  input  logic                         tdi,
  input  logic [DATA_W-1:0]            cap_data,
  output logic [DATA_W+ADDR_W:0]       frame,
  output logic                         tdo
);
  localparam int FRAME_W = DATA_W + ADDR_W + 1;

  logic [FRAME_W-1:0] sr_q;

  // capture wins over shift; the control and address bits come back as zero
  always_ff @(posedge clk) begin
    if (!rst_n) begin
      sr_q <= '0;
    end else if (capture_en) begin
      sr_q <= {{(ADDR_W+1){1'b0}}, cap_data};
    end else if (shift_en) begin
      sr_q <= {tdi, sr_q[FRAME_W-1:1]};
    end
  end

  assign frame = sr_q;
  assign tdo   = sr_q[0];
endmodule

// File: rtl/scan_update_decoder.sv
module scan_update_decoder
  import scan_port_pkg::*;
#(
  parameter int DATA_W = 32,
  parameter int ADDR_W = 7
) (
  input  logic                   clk,
  input  logic                   rst_n,
  input  logic                   update_en,
  input  logic [DATA_W+ADDR_W:0] frame,
  output logic [ADDR_W-1:0]      bank_addr,
  output logic [DATA_W-1:0]      bank_wr_data,
  output logic                   bank_wr_en,
  output logic                   bank_rd_en
);
  localparam int DIR_POS = DATA_W + ADDR_W;

  function automatic logic [ADDR_W-1:0] field_addr(input logic [DIR_POS:0] f);
    return f[DIR_POS-1:DATA_W];
  endfunction

  function automatic logic [DATA_W-1:0] field_data(input logic [DIR_POS:0] f);
    return f[DATA_W-1:0];
  endfunction

  function automatic scan_dir_e field_dir(input logic [DIR_POS:0] f);
    return scan_dir_e'(f[DIR_POS]);
  endfunction

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      bank_addr    <= '0;
      bank_wr_data <= '0;
      bank_wr_en   <= 1'b0;
      bank_rd_en   <= 1'b0;
    end else begin
      bank_wr_en <= update_en && (field_dir(frame) == DIR_WRITE);
      bank_rd_en <= update_en && (field_dir(frame) == DIR_READ);
      if (update_en) begin
        bank_addr    <= field_addr(frame);
        bank_wr_data <= field_data(frame);
      end
    end
  end
endmodule

// File: rtl/scan_read_latch.sv
module scan_read_latch #(
  parameter int DATA_W = 32
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              bank_rd_en,
  input  logic [DATA_W-1:0] bank_rd_data,
  output logic [DATA_W-1:0] rd_hold
);
  always_ff @(posedge clk) begin
    if (!rst_n) begin
      rd_hold <= '0;
    end else if (bank_rd_en) begin
      rd_hold <= bank_rd_data;
    end
  end
endmodule

// File: rtl/scan_reg_port.sv
module scan_reg_port
  import scan_port_pkg::*;
#(
  parameter int DATA_W = SP_DATA_W,
  parameter int ADDR_W = SP_ADDR_W
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              capture_en,
  input  logic              shift_en,
  input  logic              update_en,
  input  logic              tdi,
  output logic              tdo,
  output logic [ADDR_W-1:0] bank_addr,
  output logic [DATA_W-1:0] bank_wr_data,
  output logic              bank_wr_en,
  output logic              bank_rd_en,
  input  logic [DATA_W-1:0] bank_rd_data
);
  localparam int FRAME_W = DATA_W + ADDR_W + 1;

  logic [FRAME_W-1:0] frame_w;
  logic [DATA_W-1:0]  rd_hold_w;

  scan_frame_shifter #(.DATA_W(DATA_W), .ADDR_W(ADDR_W)) shifter_i (
    .clk        (clk),
    .rst_n      (rst_n),
    .capture_en (capture_en),
    .shift_en   (shift_en),
    .tdi        (tdi),
    .cap_data   (rd_hold_w),
    .frame      (frame_w),
    .tdo        (tdo)
  );

  scan_update_decoder #(.DATA_W(DATA_W), .ADDR_W(ADDR_W)) decoder_i (
    .clk          (clk),
    .rst_n        (rst_n),
    .update_en    (update_en),
    .frame        (frame_w),
    .bank_addr    (bank_addr),
    .bank_wr_data (bank_wr_data),
    .bank_wr_en   (bank_wr_en),
    .bank_rd_en   (bank_rd_en)
  );

  scan_read_latch #(.DATA_W(DATA_W)) latch_i (
    .clk          (clk),
    .rst_n        (rst_n),
    .bank_rd_en   (bank_rd_en),
    .bank_rd_data (bank_rd_data),
    .rd_hold      (rd_hold_w)
  );
endmodule

// File: rtl/scan_reg_port_chk.sv
module scan_reg_port_chk (
  input logic clk,
  input logic rst_n,
  input logic capture_en,
  input logic shift_en,
  input logic update_en,
  input logic tdo,
  input logic bank_wr_en,
  input logic bank_rd_en
);
  AST_STROBE_EXCL: assert property (@(posedge clk) disable iff (!rst_n)
    !(bank_rd_en && bank_wr_en)); // R2
  AST_RD_ONE_CYCLE: assert property (@(posedge clk) disable iff (!rst_n)
    bank_rd_en |=> !bank_rd_en); // R6
  AST_WR_ONE_CYCLE: assert property (@(posedge clk) disable iff (!rst_n)
    bank_wr_en |=> !bank_wr_en); // R2
  AST_RD_AFTER_UPDATE: assert property (@(posedge clk) disable iff (!rst_n)
    bank_rd_en |-> $past(update_en)); // R3
  AST_WR_AFTER_UPDATE: assert property (@(posedge clk) disable iff (!rst_n)
    bank_wr_en |-> $past(update_en)); // R7
  AST_TDO_HOLDS: assert property (@(posedge clk) disable iff (!rst_n)
    (!shift_en && !capture_en) |=> $stable(tdo)); // R1
endmodule

bind scan_reg_port scan_reg_port_chk chk_i (
  .clk        (clk),
  .rst_n      (rst_n),
  .capture_en (capture_en),
  .shift_en   (shift_en),
  .update_en  (update_en),
  .tdo        (tdo),
  .bank_wr_en (bank_wr_en),
  .bank_rd_en (bank_rd_en)
);

// File: tb/scan_reg_port_tb_top.sv
module scan_reg_port_tb_top;
  localparam logic [31:0] ID_WORD = 32'hC0DE_0001;

  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        capture_en = 1'b0;
  logic        shift_en = 1'b0;
  logic        update_en = 1'b0;
  logic        tdi = 1'b0;
  logic        tdo;
  logic [6:0]  bank_addr;
  logic [31:0] bank_wr_data;
  logic        bank_wr_en;
  logic        bank_rd_en;
  logic [31:0] bank_rd_data;

  int checks = 0;
  int errors = 0;
  bit finished = 0;

  always #5 clk = ~clk;

  scan_reg_port dut_i (
    .clk(clk), .rst_n(rst_n), .capture_en(capture_en), .shift_en(shift_en),
    .update_en(update_en), .tdi(tdi), .tdo(tdo), .bank_addr(bank_addr),
    .bank_wr_data(bank_wr_data), .bank_wr_en(bank_wr_en),
    .bank_rd_en(bank_rd_en), .bank_rd_data(bank_rd_data)
  );

  // register bank: 0 = read-only id, 4 = RAM window with auto-advance, 5 = window pointer
  logic [31:0] breg [0:7];
  logic [31:0] bmem [0:15];
  logic [3:0]  bptr = 4'd0;

  function automatic logic [31:0] mem_init(input int i);
    return 32'hA500_0000 + i * 32'h0001_0203;
  endfunction

  initial begin
    for (int i = 0; i < 16; i++) bmem[i] = mem_init(i);
    for (int i = 0; i < 8; i++) breg[i] = 32'h0;
  end

  assign bank_rd_data = (bank_addr == 7'd0) ? ID_WORD :
                        (bank_addr == 7'd4) ? bmem[bptr] :
                        (bank_addr == 7'd5) ? {28'd0, bptr} : breg[bank_addr[2:0]];

  always @(posedge clk) begin
    if (bank_wr_en) begin
      if (bank_addr == 7'd5) bptr <= bank_wr_data[3:0];
      else if (bank_addr == 7'd4) begin bmem[bptr] <= bank_wr_data; bptr <= bptr + 4'd1; end
      else if (bank_addr != 7'd0) breg[bank_addr[2:0]] <= bank_wr_data;
    end
    if (bank_rd_en && bank_addr == 7'd4) bptr <= bptr + 4'd1;
  end

  task automatic check(input bit ok, input string tag, input logic [63:0] act, input logic [63:0] exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
    end
  endtask

  // behavioural reference: bit queue for the chain, expected strobe per cycle
  bit          q[$];
  logic [31:0] hold_m;
  bit          exp_rd, exp_wr;
  logic [6:0]  exp_addr;
  logic [31:0] exp_data;

  initial begin
    for (int i = 0; i < 40; i++) q.push_back(1'b0);
    hold_m = 0; exp_rd = 0; exp_wr = 0; exp_addr = 0; exp_data = 0;
  end

  always @(posedge clk) begin
    if (!rst_n) begin
      q.delete();
      for (int i = 0; i < 40; i++) q.push_back(1'b0);
      hold_m = 0; exp_rd = 0; exp_wr = 0;
    end else begin
      if (exp_rd) hold_m = bank_rd_data;
      exp_rd = 0; exp_wr = 0;
      if (update_en) begin
        exp_data = 0; exp_addr = 0;
        for (int i = 0; i < 32; i++) exp_data[i] = q[i];
        for (int i = 0; i < 7; i++) exp_addr[i] = q[32 + i];
        if (q[39]) exp_wr = 1; else exp_rd = 1;
      end
      if (capture_en) begin
        q.delete();
        for (int i = 0; i < 32; i++) q.push_back(hold_m[i]);
        for (int i = 0; i < 8; i++) q.push_back(1'b0);
      end else if (shift_en) begin
        void'(q.pop_front());
        q.push_back(tdi);
      end
    end
  end

  always @(negedge clk) begin
    if (rst_n) begin
      check(tdo == q[0], "R1 tdo bit", tdo, q[0]);
      check(bank_rd_en == exp_rd, "R3 read strobe", bank_rd_en, exp_rd);
      check(bank_wr_en == exp_wr, "R2 write strobe", bank_wr_en, exp_wr);
      if (exp_rd || exp_wr)
        check(bank_addr == exp_addr, "R2 R3 bank address", bank_addr, exp_addr);
      if (exp_wr)
        check(bank_wr_data == exp_data, "R2 write data", bank_wr_data, exp_data);
    end
  end

  task automatic scan(input logic dir, input logic [6:0] addr, input logic [31:0] data,
                      output logic [39:0] got);
    logic [39:0] f;
    f = {dir, addr, data};
    @(negedge clk); capture_en = 1'b1;
    @(negedge clk); capture_en = 1'b0;
    for (int i = 0; i < 40; i++) begin
      shift_en = 1'b1; tdi = f[i]; got[i] = tdo;
      @(negedge clk);
    end
    shift_en = 1'b0; update_en = 1'b1;
    @(negedge clk); update_en = 1'b0;
    @(negedge clk);
    @(negedge clk);
  endtask

  initial begin
    repeat (100000) @(posedge clk);
    if (!finished) begin
      errors++;
      $display("FAIL watchdog expired");
      $display("CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
    end
  end

  initial begin
    logic [39:0] g;
    repeat (3) @(negedge clk);
    check(tdo == 1'b0, "R8 reset tdo", tdo, 0);
    check(!bank_rd_en && !bank_wr_en, "R8 reset strobes", {bank_rd_en, bank_wr_en}, 0);
    rst_n = 1'b1;
    @(negedge clk);

    scan(1'b1, 7'd1, 32'h1111_1111, g);
    check(g[31:0] == 32'h0, "R8 reset read word", g[31:0], 0);
    scan(1'b1, 7'd2, 32'h2222_2222, g);
    scan(1'b0, 7'd1, 32'h0, g);
    check(g[31:0] == 32'h0, "R7 writes keep held word", g[31:0], 0);
    scan(1'b0, 7'd2, 32'h0, g);
    check(g[31:0] == 32'h1111_1111, "R4 read lag", g[31:0], 32'h1111_1111);
    check(g[39:32] == 8'h0, "R5 control bits zero", g[39:32], 0);
    scan(1'b1, 7'd3, 32'h3333_3333, g);
    check(g[31:0] == 32'h2222_2222, "R4 second read", g[31:0], 32'h2222_2222);
    scan(1'b1, 7'd3, 32'h3434_3434, g);
    check(g[31:0] == 32'h2222_2222, "R7 held across write", g[31:0], 32'h2222_2222);
    check(breg[3] == 32'h3434_3434, "R2 write landed", breg[3], 32'h3434_3434);

    scan(1'b1, 7'd5, 32'h0, g);
    for (int k = 0; k < 4; k++) begin
      scan(1'b0, 7'd4, 32'h0, g);
      if (k > 0) check(g[31:0] == mem_init(k - 1), "R6 burst word", g[31:0], mem_init(k - 1));
    end
    scan(1'b0, 7'd0, 32'h0, g);
    check(g[31:0] == mem_init(3), "R6 last burst word", g[31:0], mem_init(3));
    scan(1'b0, 7'd5, 32'h0, g);
    check(g[31:0] == ID_WORD, "R6 dummy id read", g[31:0], ID_WORD);
    scan(1'b0, 7'd0, 32'h0, g);
    check(g[31:0] == 32'd4, "R6 window advanced once per read", g[31:0], 4);
    check(g[39:32] == 8'h0, "R5 control bits zero", g[39:32], 0);

    repeat (5) begin
      @(negedge clk); capture_en = 1'b1;
      @(negedge clk); capture_en = 1'b0; shift_en = 1'b1;
      @(negedge clk); shift_en = 1'b0;
    end
    check(bptr == 4'd4, "R7 no access without update", bptr, 4);

    finished = 1;
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end
endmodule